// File: doc/BRIEF.md
# Latched Fault Capture Register

This block records which of twelve monitored logic signals changed state first. There are seven supply-fault outputs, four general-purpose input levels and one watchdog fault. The block shows them in two 8-bit read registers, a low byte and a high byte. While nothing has changed, the registers follow the live, masked input levels. Bit 7 of the low byte is a summary flag. It sets when any unmasked input differs from the value recorded at the last clearing read. While the flag is set, both registers hold the snapshot taken when the change was detected. A controller can therefore compare it with its previous reading and find the input that moved first.

The bus protocol sits outside the block, which sees only one read strobe per register. A read of the low byte has no side effect. A read of the high byte clears the flag. The next comparison then uses the snapshot the controller has just read as its reference. A change that arrived while the registers were frozen, or in the same cycle as the clearing read, is therefore reported again. Two mask bytes with the same bit layout force individual data bits to 0. The summary flag cannot be masked.

Top module: `flt_capture`

## Requirements
- R1: With the flag clear, the outputs show the live masked inputs with no clock delay. Low byte bits 3..6 carry supply faults 0..3. High byte bits 0..2 carry supply faults 4..6, bits 3..6 carry general inputs 0..3, and bit 7 carries the watchdog fault. Low byte bits 0..2 always read 0.
- R2: If an unmasked input differs from the stored reference at a rising clock edge, the flag (low byte bit 7) reads 1 after that edge. The registers then hold the input values sampled at that edge, so a fault on supply 0 alone reads low byte 8'h88.
- R3: While the flag is set, input changes do not alter either register.
- R4: When rd_hi is high at a rising edge while the flag is set, the flag reads 0 after that edge. The frozen snapshot becomes the reference for the next comparison.
- R5: Strobing rd_lo, with rd_hi low, leaves the flag and both registers unchanged.
- R6: A 1 in mask_lo bit k (k in 0..6) or mask_hi bit k forces the matching output bit to 0 at all times, frozen or live.
- R7: Mask bit 7 of mask_lo does not suppress the summary flag. A change on a masked input never sets the flag.
- R8: If an input change coincides with the clearing read, the flag clears for one cycle and then sets again, holding the new value.
- R9: After reset the flag is 0 and the reference is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_flt | input | 7 | Supply-fault outputs, 1 = fault |
| gp_in | input | 4 | General-purpose input levels |
| wd_flt | input | 1 | Watchdog fault |
| mask_lo | input | 8 | Mask for low byte bits 0..6 (bit 7 has no effect) |
| mask_hi | input | 8 | Mask for high byte bits 0..7 |
| rd_lo | input | 1 | Read strobe for the low byte |
| rd_hi | input | 1 | Read strobe for the high byte; clears the flag |
| dout_lo | output | 8 | Low byte: flag in bit 7, data in bits 0..6 |
| dout_hi | output | 8 | High byte data |

## Verification
The block has a fixed twelve-input layout and no parameter overrides, so the bench builds it as declared. All fifteen data bit positions and both mask bytes are reachable. Directed sequences cover the supply 0 example, the role of the snapshot as the next reference, and a change that coincides with the clearing read. Random stimulus uses sparse bit flips and frequent clearing reads, which drive many freeze-and-rearm cycles under changing masks.

// File: rtl/flt_capture.sv
module flt_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] sup_flt,
  input  logic [3:0] gp_in,
  input  logic       wd_flt,
  input  logic [7:0] mask_lo,
  input  logic [7:0] mask_hi,
  input  logic       rd_lo,
  input  logic       rd_hi,
  output logic [7:0] dout_lo,
  output logic [7:0] dout_hi
);
  localparam int NSUP = 7;
  localparam int NGP  = 4;
  localparam int PAD  = 3;
  localparam int W    = PAD + NSUP + NGP + 1;

  logic [W-1:0] live, msk, snap_q, shown;
  logic         flag_q, chg;

  assign live  = {wd_flt, gp_in, sup_flt, {PAD{1'b0}}};
  assign msk   = {mask_hi, mask_lo[6:0]};
  assign chg   = |((live ^ snap_q) & ~msk);
  assign shown = (flag_q ? snap_q : live) & ~msk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      snap_q <= '0;
    end else if (!flag_q) begin
      snap_q <= live;
      flag_q <= chg;
    end else if (rd_hi) begin
      flag_q <= 1'b0;
    end
  end

  assign dout_lo = {flag_q, shown[6:0]};
  assign dout_hi = shown[W-1:7];

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && chg) |=> dout_lo[7]);  // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_hi) |=> $stable(snap_q) && flag_q);  // R3
  AST_HI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && rd_hi) |=> !dout_lo[7]);  // R4
  AST_LO_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && rd_lo && !rd_hi) |=> dout_lo[7]);  // R5
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_lo[6:0] & mask_lo[6:0]) == 7'd0) && ((dout_hi & mask_hi) == 8'd0));  // R6
  AST_FLAG_UNMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && chg && mask_lo[7]) |=> dout_lo[7]);  // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dout_lo[2:0] == 3'd0);  // R1
endmodule

// File: tb/flt_capture_tb_top.sv
module flt_capture_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] sup_flt = '0;
  logic [3:0] gp_in = '0;
  logic wd_flt = 1'b0;
  logic [7:0] mask_lo = '0, mask_hi = '0;
  logic rd_lo = 1'b0, rd_hi = 1'b0;
  logic [7:0] dout_lo, dout_hi;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit flag_m = 0;
  logic [14:0] ref_m = '0;

  always #(CLK_P/2) clk = ~clk;

  flt_capture dut_i (.clk(clk), .rst_n(rst_n), .sup_flt(sup_flt), .gp_in(gp_in),
    .wd_flt(wd_flt), .mask_lo(mask_lo), .mask_hi(mask_hi), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .dout_lo(dout_lo), .dout_hi(dout_hi));

  function automatic logic [14:0] pack_in();
    return {wd_flt, gp_in, sup_flt, 3'b000};
  endfunction

  function automatic logic [15:0] expect_out();
    logic [14:0] m, v;
    m = {mask_hi, mask_lo[6:0]};
    v = (flag_m ? ref_m : pack_in()) & ~m;
    return {v[14:7], flag_m, v[6:0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] elo, input logic [7:0] ehi);
    n_chk++;
    if (dout_lo !== elo || dout_hi !== ehi) begin
      n_bad++;
      $display("FAIL %s: got lo=%h hi=%h expected lo=%h hi=%h", tag, dout_lo, dout_hi, elo, ehi);
    end
  endtask

  task automatic chk_model(input string tag);
    logic [15:0] e;
    e = expect_out();
    chk(tag, e[7:0], e[15:8]);
  endtask

  task automatic drive(input logic [6:0] s, input logic [3:0] g, input logic w,
                       input logic rl, input logic rh);
    sup_flt = s; gp_in = g; wd_flt = w; rd_lo = rl; rd_hi = rh;
    #1;
  endtask

  task automatic adv();
    logic [14:0] m, v;
    @(posedge clk);
    m = {mask_hi, mask_lo[6:0]};
    v = pack_in();
    if (!rst_n) begin
      flag_m = 0; ref_m = '0;
    end else if (!flag_m) begin
      flag_m = |((v ^ ref_m) & ~m);
      ref_m = v;
    end else if (rd_hi) begin
      flag_m = 0;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    adv(); adv();
    rst_n = 1'b1;
    adv();
    chk("R9 reset", 8'h00, 8'h00);

    drive(7'h01, 4'h0, 0, 0, 0);
    chk("R1 live supply0", 8'h08, 8'h00);
    adv();
    chk("R2 flag supply0", 8'h88, 8'h00);
    drive(7'h00, 4'h0, 0, 0, 0);
    chk("R3 frozen", 8'h88, 8'h00);
    adv();
    chk("R3 frozen after edge", 8'h88, 8'h00);
    drive(7'h00, 4'h0, 0, 1, 0);
    adv();
    drive(7'h00, 4'h0, 0, 0, 0);
    chk("R5 rd_lo no clear", 8'h88, 8'h00);
    drive(7'h00, 4'h0, 0, 0, 1);
    adv();
    drive(7'h00, 4'h0, 0, 0, 0);
    chk("R4 cleared", 8'h00, 8'h00);
    adv();
    chk("R4 snapshot is reference", 8'h80, 8'h00);
    drive(7'h00, 4'h0, 0, 0, 1); adv();
    drive(7'h00, 4'h0, 0, 0, 0); adv();
    chk("R4 quiet after clear", 8'h00, 8'h00);

    drive(7'h00, 4'h5, 0, 0, 0); adv();
    chk("R1 gp positions", 8'h80, 8'h28);
    drive(7'h00, 4'h0, 0, 0, 1); adv();
    drive(7'h00, 4'h0, 0, 0, 0);
    chk("R8 clear cycle", 8'h00, 8'h00);
    adv();
    chk("R8 change kept", 8'h80, 8'h00);
    drive(7'h00, 4'h0, 0, 0, 1); adv();
    drive(7'h00, 4'h0, 0, 0, 0); adv();

    mask_hi = 8'h80;
    drive(7'h00, 4'h0, 1, 0, 0);
    chk("R6 masked watchdog", 8'h00, 8'h00);
    adv();
    chk("R7 masked change no flag", 8'h00, 8'h00);
    mask_lo = 8'h80;
    drive(7'h02, 4'h0, 1, 0, 0);
    chk("R1 live supply1", 8'h10, 8'h00);
    adv();
    chk("R7 flag unmaskable", 8'h90, 8'h00);
    mask_lo = 8'h90;
    #1;
    chk("R6 mask on frozen", 8'h80, 8'h00);
    mask_lo = 8'h00; mask_hi = 8'h00;
    drive(7'h02, 4'h0, 1, 0, 1); adv();
    drive(7'h02, 4'h0, 1, 0, 0); adv();
    drive(7'h02, 4'h0, 1, 0, 1); adv();
    drive(7'h02, 4'h0, 1, 0, 0); adv();
    chk_model("R4 settle");

    void'($urandom(32'h5eed));
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] s;
      logic [3:0] g;
      logic w;
      s = sup_flt ^ (7'($urandom) & 7'($urandom) & 7'($urandom));
      g = gp_in ^ (4'($urandom) & 4'($urandom) & 4'($urandom));
      w = wd_flt ^ (($urandom % 8) == 0);
      if (($urandom % 16) == 0) begin
        mask_lo = 8'($urandom) & 8'($urandom);
        mask_hi = 8'($urandom) & 8'($urandom);
      end
      drive(s, g, w, ($urandom % 3) == 0, ($urandom % 4) == 0);
      chk_model(flag_m ? "R3 random frozen" : "R1 random live");
      adv();
      chk_model(rd_hi ? "R4 random after read" : "R2 random after edge");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule